// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block makes the per-endpoint handshake decisions for a low-speed USB device function with one bidirectional control endpoint (endpoint 0) and two transmit-only interrupt endpoints (1 and 2). A packet decoder ahead of it delivers pre-digested events: a token event with its PID class, device address and endpoint number, a data event with the received toggle, byte count, CRC verdict and up to eight payload bytes, and a pulse when the host acknowledges data the device sent. For each transaction the block answers with ACK, NAK, STALL, a data packet, or silence, and it updates the endpoint status and interrupt flags.

Firmware talks to the block through a byte-wide register port that holds the device address, the per-endpoint ready, stall, toggle and enable flags, the transmit byte counts, the interrupt flags and three 8-byte transmit buffers. The 8-byte receive buffer of endpoint 0 can be read through the same port. Transmit readiness and receive readiness are both armed by firmware and dropped by hardware once a transfer completes, so each buffer handover needs one firmware action.

Top module: `usb_ep_handshake`

## Requirements
- R1: The device address register (address 0x00, bits 6:0) resets to 0. A token whose address differs from it produces no response and changes no flag.
- R2: Data following a SETUP token to endpoint 0 with a good CRC is always stored and answered with ACK, whatever the receive-ready, stall and control-read flags hold.
- R3: Data following an OUT token to endpoint 0 is stored and answered with ACK only when the endpoint 0 stall flag is clear, the control-read guard does not apply and receive-ready is set. Data without a preceding matching token is ignored.
- R4: An OUT to endpoint 0 that reaches the ready test with receive-ready clear is answered with NAK and stores nothing.
- R5: A store clears receive-ready, sets interrupt bit 0 and writes the status register (address 0x03) as: bits 3:0 byte count, bit 4 received toggle (1 for DATA1), bit 5 SETUP indicator, bit 6 direction (0), bit 7 error, set when the count exceeds 8. Only the first 8 bytes are kept.
- R6: An IN token to an enabled endpoint whose stall flag is clear and transmit-ready flag is set is answered with a data packet carrying that endpoint's byte count, its 8 buffer bytes (byte 0 in the low bits) and a DATA1 PID when its toggle bit is 1.
- R7: A host acknowledge that directly follows a data response clears that endpoint's transmit-ready flag and sets its interrupt bit (bit 1+n for endpoint n); for endpoint 0 it also sets status bit 6. An acknowledge at any other time changes nothing.
- R8: Endpoints 1 and 2 answer IN tokens only while their enable bit is set; OUT and SETUP tokens to them, and any token to endpoint 3 or above, get no response.
- R9: While the control-read bit is set, an OUT to endpoint 0 whose data is DATA0 or whose byte count is non-zero is answered with STALL and stores nothing.
- R10: A set stall flag answers IN tokens and endpoint 0 OUT data with STALL, ahead of the control-read and ready tests; an enabled, unstalled IN endpoint whose transmit-ready is clear gets NAK.
- R11: The interrupt register (address 0x01) clears a bit when 0 is written to it; writing 1 leaves the bit unchanged.
- R12: Data with a bad CRC gets no response and changes no flag or status.
- R13: The response appears on `rsp_valid` for exactly one cycle, one clock after the event; `rsp_kind` codes are 1 ACK, 2 NAK, 3 STALL, 4 DATA. Token PID codes are 0 OUT, 1 IN, 2 SETUP. Register reads return one clock after the address is presented. Map: 0x02 bit 0 receive-ready, bit 1 control-read; 0x04+n endpoint n control with bit 0 ready, bit 1 toggle, bit 2 stall, bit 3 enable (reads 1 for endpoint 0); 0x08+n byte count; 0x10-0x17 receive buffer; 0x18+8n transmit buffer n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token event strobe |
| tok_pid | input | 2 | Token class: 0 OUT, 1 IN, 2 SETUP |
| tok_addr | input | 7 | Device address carried by the token |
| tok_ep | input | 4 | Endpoint number carried by the token |
| dat_valid | input | 1 | Received data packet strobe |
| dat_tgl | input | 1 | Received data PID is DATA1 |
| dat_cnt | input | 4 | Received payload byte count |
| dat_crc_ok | input | 1 | Received packet CRC is good |
| dat_bytes | input | 64 | Received payload, byte 0 in bits 7:0 |
| hs_ack | input | 1 | Host acknowledged transmitted data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 3 | Response: 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| rsp_tgl | output | 1 | Data response uses DATA1 |
| rsp_cnt | output | 4 | Data response byte count |
| rsp_bytes | output | 64 | Data response payload |

## Verification
IN tokens are swept over every endpoint against all combinations of enable, stall and ready, with toggles and counts varied per case, so the priority of silence, STALL, NAK and data is separated per endpoint. Endpoint 0 OUT data is swept over stall, ready, control-read, toggle and zero or non-zero length, which separates the guard from the NAK path and from plain storage. SETUP data is swept against the same flags to show that nothing blocks it, and bad-CRC, wrong-address, stray-data and stray-acknowledge patterns show that flags stay put when they should.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  localparam int EP_COUNT  = 3;
  localparam int EP_IDX_W  = $clog2(EP_COUNT);
  localparam int EP_W      = 4;
  localparam int BUF_DEPTH = 8;
  localparam int BUF_AW    = $clog2(BUF_DEPTH);
  localparam int BYTE_W    = 8;
  localparam int BUF_BITS  = BUF_DEPTH * BYTE_W;
  localparam int CNT_W     = 4;
  localparam int RA_W      = 6;
  localparam int IRQ_W     = EP_COUNT + 1;

  localparam int A_ADDR  = 0;
  localparam int A_IRQ   = 1;
  localparam int A_RXCTL = 2;
  localparam int A_RXST  = 3;
  localparam int A_TXCTL = 4;
  localparam int A_TXCNT = 8;
  localparam int A_RXBUF = 16;
  localparam int A_TXBUF = 24;

  typedef enum logic [1:0] {TK_OUT = 2'd0, TK_IN = 2'd1, TK_SETUP = 2'd2} tok_e;
  typedef enum logic [2:0] {
    RS_NONE = 3'd0, RS_ACK = 3'd1, RS_NAK = 3'd2, RS_STALL = 3'd3, RS_DATA = 3'd4
  } rsp_e;
endpackage

// File: rtl/usb_ep_bytebuf.sv
module usb_ep_bytebuf #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [W-1:0]       wdata,
  input  logic               ld,
  input  logic [DEPTH*W-1:0] ldata,
  output logic [DEPTH*W-1:0] q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ldata[i*W +: W];
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_q
    assign q[g*W +: W] = mem[g];
  end
endmodule

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_hs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                tok_valid,
  input  logic [1:0]          tok_pid,
  input  logic [ADDR_W-1:0]   tok_addr,
  input  logic [EP_W-1:0]     tok_ep,
  input  logic [ADDR_W-1:0]   dev_addr,
  input  logic                dat_valid,
  input  logic                dat_tgl,
  input  logic [CNT_W-1:0]    dat_cnt,
  input  logic                dat_crc_ok,
  input  logic                hs_ack,
  input  logic                pend_valid,
  input  logic                pend_setup,
  input  logic                await_valid,
  input  logic [EP_COUNT-1:0] tx_rdy,
  input  logic [EP_COUNT-1:0] ep_stall,
  input  logic [EP_COUNT-1:0] ep_en,
  input  logic                rx_rdy,
  input  logic                ctrl_rd,
  output logic [2:0]          kind,
  output logic [EP_IDX_W-1:0] sel,
  output logic                open_pend,
  output logic                open_setup,
  output logic                store,
  output logic                arm_in,
  output logic                finish_in
);
  logic hit;
  logic guard_trip;

  assign sel        = tok_ep[EP_IDX_W-1:0];
  assign hit        = tok_valid && (tok_addr == dev_addr) && (tok_ep < EP_W'(EP_COUNT));
  assign guard_trip = ctrl_rd && (!dat_tgl || (dat_cnt != '0));

  always_comb begin
    kind       = RS_NONE;
    open_pend  = 1'b0;
    open_setup = 1'b0;
    store      = 1'b0;
    arm_in     = 1'b0;
    finish_in  = 1'b0;
    if (hit && tok_pid == TK_IN) begin
      if (ep_en[sel]) begin
        if (ep_stall[sel])    kind = RS_STALL;
        else if (!tx_rdy[sel]) kind = RS_NAK;
        else begin
          kind   = RS_DATA;
          arm_in = 1'b1;
        end
      end
    end else if (hit && tok_ep == '0 && (tok_pid == TK_OUT || tok_pid == TK_SETUP)) begin
      open_pend  = 1'b1;
      open_setup = (tok_pid == TK_SETUP);
    end
    if (dat_valid && pend_valid && dat_crc_ok) begin
      if (pend_setup) begin
        store = 1'b1;
        kind  = RS_ACK;
      end else if (ep_stall[0] || guard_trip) begin
        kind = RS_STALL;
      end else if (!rx_rdy) begin
        kind = RS_NAK;
      end else begin
        store = 1'b1;
        kind  = RS_ACK;
      end
    end
    if (hs_ack && await_valid) finish_in = 1'b1;
  end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_hs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tok_valid,
  input  logic [1:0]          tok_pid,
  input  logic [ADDR_W-1:0]   tok_addr,
  input  logic [EP_W-1:0]     tok_ep,
  input  logic                dat_valid,
  input  logic                dat_tgl,
  input  logic [CNT_W-1:0]    dat_cnt,
  input  logic                dat_crc_ok,
  input  logic [BUF_BITS-1:0] dat_bytes,
  input  logic                hs_ack,
  input  logic                reg_we,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  output logic                rsp_valid,
  output logic [2:0]          rsp_kind,
  output logic                rsp_tgl,
  output logic [CNT_W-1:0]    rsp_cnt,
  output logic [BUF_BITS-1:0] rsp_bytes
);
  localparam int RG_W = RA_W - BUF_AW;

  logic [ADDR_W-1:0]   dev_addr;
  logic [IRQ_W-1:0]    irq;
  logic                rx_rdy, ctrl_rd;
  logic [CNT_W-1:0]    rx_cnt;
  logic                rx_tgl, rx_setup, rx_err, ep0_dir;
  logic [EP_COUNT-1:0] tx_rdy, tx_tgl, ep_stall;
  logic [EP_COUNT-1:1] cfg_hi;
  logic [EP_COUNT-1:0] en_vec;
  logic [CNT_W-1:0]    tx_cnt [EP_COUNT];
  logic                pend_valid, pend_setup, await_valid;
  logic [EP_IDX_W-1:0] await_ep;
  logic [BUF_BITS-1:0] rxq;
  logic [BUF_BITS-1:0] txq [EP_COUNT];
  logic [BYTE_W-1:0]   rd_val;

  logic [2:0]          kind;
  logic [EP_IDX_W-1:0] sel;
  logic                open_pend, open_setup, store, arm_in, finish_in;

  assign en_vec = {cfg_hi, 1'b1};

  usb_ep_decide #(.ADDR_W(ADDR_W)) u_decide (
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .dev_addr(dev_addr), .dat_valid(dat_valid), .dat_tgl(dat_tgl), .dat_cnt(dat_cnt),
    .dat_crc_ok(dat_crc_ok), .hs_ack(hs_ack), .pend_valid(pend_valid),
    .pend_setup(pend_setup), .await_valid(await_valid), .tx_rdy(tx_rdy),
    .ep_stall(ep_stall), .ep_en(en_vec), .rx_rdy(rx_rdy), .ctrl_rd(ctrl_rd),
    .kind(kind), .sel(sel), .open_pend(open_pend), .open_setup(open_setup),
    .store(store), .arm_in(arm_in), .finish_in(finish_in)
  );

  usb_ep_bytebuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_rxbuf (
    .clk(clk), .we(1'b0), .waddr('0), .wdata('0),
    .ld(store), .ldata(dat_bytes), .q(rxq)
  );

  for (genvar n = 0; n < EP_COUNT; n++) begin : g_txbuf
    logic we_n;
    assign we_n = reg_we && (reg_addr[RA_W-1:BUF_AW] == RG_W'(A_TXBUF / BUF_DEPTH + n));
    usb_ep_bytebuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_txbuf (
      .clk(clk), .we(we_n), .waddr(reg_addr[BUF_AW-1:0]), .wdata(reg_wdata),
      .ld(1'b0), .ldata('0), .q(txq[n])
    );
  end

  // Firmware writes first, hardware updates after them so hardware wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_addr <= '0; irq <= '0; rx_rdy <= 1'b0; ctrl_rd <= 1'b0;
      rx_cnt <= '0; rx_tgl <= 1'b0; rx_setup <= 1'b0; rx_err <= 1'b0; ep0_dir <= 1'b0;
      tx_rdy <= '0; tx_tgl <= '0; ep_stall <= '0; cfg_hi <= '0;
      for (int n = 0; n < EP_COUNT; n++) tx_cnt[n] <= '0;
      pend_valid <= 1'b0; pend_setup <= 1'b0; await_valid <= 1'b0; await_ep <= '0;
    end else begin
      if (reg_we && reg_addr == RA_W'(A_ADDR)) dev_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_addr == RA_W'(A_IRQ))  irq <= irq & reg_wdata[IRQ_W-1:0];
      if (reg_we && reg_addr == RA_W'(A_RXCTL)) begin
        rx_rdy  <= reg_wdata[0];
        ctrl_rd <= reg_wdata[1];
      end
      for (int n = 0; n < EP_COUNT; n++) begin
        if (reg_we && reg_addr == RA_W'(A_TXCTL + n)) begin
          tx_rdy[n]   <= reg_wdata[0];
          tx_tgl[n]   <= reg_wdata[1];
          ep_stall[n] <= reg_wdata[2];
        end
        if (reg_we && reg_addr == RA_W'(A_TXCNT + n)) tx_cnt[n] <= reg_wdata[CNT_W-1:0];
      end
      for (int n = 1; n < EP_COUNT; n++) begin
        if (reg_we && reg_addr == RA_W'(A_TXCTL + n)) cfg_hi[n] <= reg_wdata[3];
      end
      if (store) begin
        rx_cnt   <= dat_cnt;
        rx_tgl   <= dat_tgl;
        rx_setup <= pend_setup;
        rx_err   <= (dat_cnt > CNT_W'(BUF_DEPTH));
        ep0_dir  <= 1'b0;
        rx_rdy   <= 1'b0;
        irq[0]   <= 1'b1;
      end
      if (finish_in) begin
        tx_rdy[await_ep] <= 1'b0;
        irq[{1'b0, await_ep} + 3'd1] <= 1'b1;
        if (await_ep == '0) ep0_dir <= 1'b1;
      end
      if (tok_valid || dat_valid) begin
        pend_valid  <= open_pend;
        pend_setup  <= open_setup;
        await_valid <= arm_in;
        await_ep    <= sel;
      end else if (finish_in) begin
        await_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_kind <= '0; rsp_tgl <= 1'b0; rsp_cnt <= '0; rsp_bytes <= '0;
    end else begin
      rsp_valid <= (kind != RS_NONE);
      rsp_kind  <= kind;
      if (kind == RS_DATA) begin
        rsp_tgl   <= tx_tgl[sel];
        rsp_cnt   <= tx_cnt[sel];
        rsp_bytes <= txq[sel];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      RA_W'(A_ADDR):  rd_val = BYTE_W'(dev_addr);
      RA_W'(A_IRQ):   rd_val = BYTE_W'(irq);
      RA_W'(A_RXCTL): rd_val = BYTE_W'({ctrl_rd, rx_rdy});
      RA_W'(A_RXST):  rd_val = BYTE_W'({rx_err, ep0_dir, rx_setup, rx_tgl, rx_cnt});
      default: ;
    endcase
    for (int n = 0; n < EP_COUNT; n++) begin
      if (reg_addr == RA_W'(A_TXCTL + n))
        rd_val = BYTE_W'({en_vec[n], ep_stall[n], tx_tgl[n], tx_rdy[n]});
      if (reg_addr == RA_W'(A_TXCNT + n)) rd_val = BYTE_W'(tx_cnt[n]);
      for (int i = 0; i < BUF_DEPTH; i++) begin
        if (reg_addr == RA_W'(A_TXBUF + n * BUF_DEPTH + i)) rd_val = txq[n][i*BYTE_W +: BYTE_W];
      end
    end
    for (int i = 0; i < BUF_DEPTH; i++) begin
      if (reg_addr == RA_W'(A_RXBUF + i)) rd_val = rxq[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_val;
  end

  // Assertions
  a_r1_foreign_addr_silent: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_addr != dev_addr && !dat_valid && !hs_ack) |=> !rsp_valid);

  a_r5_store_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RS_ACK) |-> (!rx_rdy && irq[0]));

  a_r4_nak_when_unready: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && pend_valid && !pend_setup && dat_crc_ok && !ep_stall[0] && !ctrl_rd && !rx_rdy)
    |=> (rsp_valid && rsp_kind == RS_NAK));

  a_r9_control_read_guard: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && pend_valid && !pend_setup && dat_crc_ok && ctrl_rd && (!dat_tgl || dat_cnt != '0))
    |=> (rsp_valid && rsp_kind == RS_STALL));

  a_r6_in_toggle: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_pid == TK_IN && tok_addr == dev_addr && tok_ep == '0 && tx_rdy[0] && !ep_stall[0])
    |=> (rsp_valid && rsp_kind == RS_DATA && rsp_tgl == $past(tx_tgl[0])));

  a_r12_bad_crc_quiet: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && !dat_crc_ok && !reg_we && !hs_ack)
    |=> (!rsp_valid && $stable(irq) && $stable(rx_rdy)));
endmodule

// File: tb/usb_ep_handshake_bench.sv
module usb_ep_handshake_bench;
  localparam logic [2:0] K_NONE = 0, K_ACK = 1, K_NAK = 2, K_STALL = 3, K_DATA = 4;
  localparam logic [1:0] P_OUT = 0, P_IN = 1, P_SETUP = 2;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 0, rst = 1;
  logic tok_valid = 0, dat_valid = 0, dat_tgl = 0, dat_crc_ok = 0, hs_ack = 0, reg_we = 0;
  logic [1:0] tok_pid = 0;
  logic [6:0] tok_addr = 0;
  logic [3:0] tok_ep = 0, dat_cnt = 0;
  logic [63:0] dat_bytes = 0;
  logic [5:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rsp_valid, rsp_tgl;
  logic [2:0] rsp_kind;
  logic [3:0] rsp_cnt;
  logic [63:0] rsp_bytes;
  int n_checks = 0, n_fail = 0;
  logic done = 0;
  logic [7:0] st_exp = 0, irq_exp = 0, v;

  usb_ep_handshake u_usb_ep_handshake (.*);

  always #10 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    reg_addr = a; @(negedge clk); d = reg_rdata;
  endtask

  task automatic tok(logic [1:0] p, logic [6:0] a, logic [3:0] e);
    tok_valid = 1; tok_pid = p; tok_addr = a; tok_ep = e;
    @(negedge clk); tok_valid = 0;
  endtask

  task automatic dat(logic t, logic [3:0] c, logic ok, logic [63:0] b);
    dat_valid = 1; dat_tgl = t; dat_cnt = c; dat_crc_ok = ok; dat_bytes = b;
    @(negedge clk); dat_valid = 0;
  endtask

  task automatic ack();
    hs_ack = 1; @(negedge clk); hs_ack = 0;
  endtask

  task automatic chk_rsp(string req, logic [2:0] ek, logic et, logic [3:0] ec, logic [63:0] eb);
    check(req, rsp_valid, ek != K_NONE);
    if (ek != K_NONE) check(req, rsp_kind, ek);
    if (ek == K_DATA) begin
      check(req, rsp_tgl, et);
      check(req, rsp_cnt, ec);
      check(req, rsp_bytes, eb);
    end
  endtask

  function automatic logic [63:0] txpat(int n);
    logic [63:0] b;
    for (int i = 0; i < 8; i++) b[i*8 +: 8] = 8'(n * 16 + i + 1);
    return b;
  endfunction

  function automatic logic [63:0] rxpat(int k);
    logic [63:0] b;
    for (int i = 0; i < 8; i++) b[i*8 +: 8] = 8'(k * 8 + i + 8'h40);
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // Reset state
    check("R13 reset rsp", rsp_valid, 0);
    for (int a = 0; a < 4; a++) begin rd(6'(a), v); check("R1 reset regs", v, 0); end
    // Fill transmit buffers
    for (int n = 0; n < 3; n++)
      for (int i = 0; i < 8; i++) wr(6'(24 + 8 * n + i), 8'(n * 16 + i + 1));
    for (int n = 0; n < 3; n++) begin rd(6'(24 + 8 * n + 5), v); check("R6 tx buffer", v, 8'(n * 16 + 6)); end
    wr(0, {1'b0, DEV}); rd(0, v); check("R1 address", v, {1'b0, DEV});

    // Foreign address
    wr(4, 8'h01); wr(8, 8'h02);
    tok(P_IN, DEV ^ 7'h01, 0); chk_rsp("R1 foreign IN", K_NONE, 0, 0, 0);
    tok(P_IN, 7'h00, 0);       chk_rsp("R1 zero addr IN", K_NONE, 0, 0, 0);
    wr(2, 8'h01);
    tok(P_OUT, DEV ^ 7'h05, 0); dat(1, 3, 1, rxpat(1)); chk_rsp("R1 foreign OUT", K_NONE, 0, 0, 0);
    rd(2, v); check("R1 foreign OUT ready kept", v, 8'h01);
    rd(1, v); check("R1 foreign OUT irq", v, 0);
    wr(4, 0); wr(2, 0);

    // IN sweep: endpoint x enable x stall x ready
    for (int e = 0; e < 3; e++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 2; r++) begin
            logic t; logic [2:0] ek;
            t = 1'((e + c + r) & 1);
            wr(6'(8 + e), 8'(e + 3));
            wr(6'(4 + e), {4'b0, 1'(c), 1'(s), t, 1'(r)});
            tok(P_IN, DEV, 4'(e));
            if (e != 0 && c == 0) ek = K_NONE;
            else if (s != 0) ek = K_STALL;
            else if (r == 0) ek = K_NAK;
            else ek = K_DATA;
            chk_rsp(ek == K_DATA ? "R6 IN data" : (ek == K_NONE ? "R8 IN disabled" : "R10 IN stall/nak"),
                    ek, t, 4'(e + 3), txpat(e));
            if (ek == K_DATA && e == 1) begin
              @(negedge clk); check("R13 one-cycle strobe", rsp_valid, 0);
            end
            wr(6'(4 + e), 0);
          end
    tok(P_IN, DEV, 3); chk_rsp("R8 endpoint 3", K_NONE, 0, 0, 0);

    // Host acknowledge per endpoint
    for (int e = 0; e < 3; e++) begin
      wr(6'(4 + e), 8'h0B);
      tok(P_IN, DEV, 4'(e)); chk_rsp("R7 IN before ack", K_DATA, 1, 4'(e + 3), txpat(e));
      ack();
      irq_exp[1 + e] = 1;
      rd(6'(4 + e), v); check("R7 ready cleared", v, 8'h0A);
      rd(1, v); check("R7 irq set", v, irq_exp);
    end
    st_exp[6] = 1;
    rd(3, v); check("R7 direction", v, st_exp);
    wr(5, 8'h09); ack(); rd(5, v); check("R7 stray ack", v, 8'h09);
    tok(P_IN, DEV, 1); tok(P_OUT, DEV, 1); chk_rsp("R8 OUT to IN-only", K_NONE, 0, 0, 0);
    ack(); rd(5, v); check("R7 ack after other token", v, 8'h09);
    rd(1, v); check("R7 irq unchanged", v, irq_exp);
    wr(5, 0);

    // Interrupt clear semantics
    wr(1, 8'hFF); rd(1, v); check("R11 write ones", v, 8'h0E);
    wr(1, 8'hFB); rd(1, v); check("R11 clear one bit", v, 8'h0A);
    wr(1, 8'h00); rd(1, v); check("R11 clear all", v, 0);

    // OUT sweep on endpoint 0
    for (int k = 0; k < 32; k++) begin
      logic s, r, c, t, stored; logic [3:0] cnt; logic [2:0] ek;
      s = k[4]; r = k[3]; c = k[2]; t = k[1]; cnt = k[0] ? 4'd5 : 4'd0;
      wr(1, 0); wr(2, {6'b0, c, r}); wr(4, {5'b0, s, 2'b0});
      tok(P_OUT, DEV, 0); chk_rsp("R3 token alone", K_NONE, 0, 0, 0);
      dat(t, cnt, 1, rxpat(k));
      stored = 0;
      if (s) ek = K_STALL;
      else if (c && (!t || cnt != 0)) ek = K_STALL;
      else if (!r) ek = K_NAK;
      else begin ek = K_ACK; stored = 1; end
      chk_rsp(s ? "R10 OUT stall" : (ek == K_STALL ? "R9 guard" : (ek == K_NAK ? "R4 nak" : "R3 accept")),
              ek, 0, 0, 0);
      rd(2, v); check("R5 ready after OUT", v, {6'b0, c, stored ? 1'b0 : r});
      rd(1, v); check("R5 irq after OUT", v, 8'(stored));
      if (stored) st_exp = {1'b0, 1'b0, 1'b0, t, cnt};
      rd(3, v); check("R5 status after OUT", v, st_exp);
      if (stored) begin
        rd(16, v); check("R3 rx byte 0", v, rxpat(k)[7:0]);
        rd(23, v); check("R3 rx byte 7", v, rxpat(k)[63:56]);
      end
    end
    wr(4, 0);

    // SETUP sweep: never blocked
    for (int k = 0; k < 8; k++) begin
      wr(1, 0); wr(2, {6'b0, k[2], k[1]}); wr(4, {5'b0, k[0], 2'b0});
      tok(P_SETUP, DEV, 0); dat(0, 8, 1, rxpat(k + 40));
      chk_rsp("R2 SETUP ack", K_ACK, 0, 0, 0);
      st_exp = 8'h28;
      rd(3, v); check("R2 SETUP status", v, st_exp);
      rd(2, v); check("R2 SETUP ready cleared", v, {6'b0, k[2], 1'b0});
      rd(1, v); check("R2 SETUP irq", v, 8'h01);
      rd(20, v); check("R2 SETUP byte 4", v, rxpat(k + 40)[39:32]);
    end
    wr(4, 0);

    // Bad CRC
    wr(1, 0); wr(2, 8'h01);
    tok(P_OUT, DEV, 0); dat(1, 2, 0, rxpat(3)); chk_rsp("R12 OUT bad crc", K_NONE, 0, 0, 0);
    tok(P_SETUP, DEV, 0); dat(0, 8, 0, rxpat(4)); chk_rsp("R12 SETUP bad crc", K_NONE, 0, 0, 0);
    rd(2, v); check("R12 ready kept", v, 8'h01);
    rd(1, v); check("R12 irq kept", v, 0);
    rd(3, v); check("R12 status kept", v, st_exp);

    // Stray data, SETUP to endpoint 1
    dat(1, 1, 1, rxpat(5)); chk_rsp("R3 stray data", K_NONE, 0, 0, 0);
    wr(5, 8'h08);
    tok(P_SETUP, DEV, 1); dat(0, 8, 1, rxpat(6)); chk_rsp("R8 SETUP to ep1", K_NONE, 0, 0, 0);
    rd(1, v); check("R8 irq kept", v, 0);

    // Oversize packet
    tok(P_OUT, DEV, 0); dat(1, 12, 1, rxpat(7)); chk_rsp("R5 oversize ack", K_ACK, 0, 0, 0);
    rd(3, v); check("R5 oversize status", v, 8'h9C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule